// File: doc/BRIEF.md
# Peripheral Read Response Parser

This block sits on the receive side of a display link controller. After a bus turnaround, the peripheral's reply is delivered as a stream of 32-bit words. The parser takes that stream and reads the 6-bit data type from the first word of each reply. It then branches on that type. An acknowledge reply yields a 16-bit error bitmap and two summary flags. A short read reply yields one or two bytes. A long read reply yields a header-announced number of payload bytes, unpacked from the words that follow.

Bytes leave the block one per cycle on a valid/last stream. The stream is cut to the maximum length the requester allows. Words the requester does not want are still consumed, so the input stream stays aligned. An unrecognised data type raises a one-cycle error pulse, and the rest of that reply is thrown away. A saturating counter reports how many words the current reply has used so far.

Top module: `rd_resp_parser`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, the outputs are: `in_ready` high, and `byte_valid`, `byte_last`, `ack_valid`, `ack_fatal`, `ack_ecc_fixed`, `type_err`, `resp_done` all low, with `ack_err` and `word_cnt` zero.
- R2: A word accepted with `in_sop` high, while no long payload is pending, is a reply header. Its type is `in_data[5:0]`: 0x02 acknowledge, 0x21 one-byte short, 0x22 two-byte short, 0x1A generic long, 0x1C DCS long. A word without `in_sop` that arrives while the block is idle is consumed and has no effect on any output.
- R3: One cycle after an acknowledge header is accepted, `ack_valid` pulses for one cycle and `ack_err` shows `in_data[23:8]`. `ack_err` keeps that value until the next acknowledge header.
- R4: Along with `ack_valid`, `ack_ecc_fixed` equals bit 8 of the bitmap. `ack_fatal` is high when any of bits 3, 4, 5, 6, 7, 9, 11, 13 or 15 is set. Bit 8 and all other bits have no effect on `ack_fatal`.
- R5: A one-byte short reply delivers `in_data[15:8]`. A two-byte short reply delivers `in_data[15:8]` and then `in_data[23:16]`. The first byte is valid in the cycle after the header is accepted, and the second follows in the next cycle.
- R6: A long reply's byte count is `{in_data[23:16], in_data[15:8]}`. The next ceil(count/4) accepted words are payload, whatever their `in_sop` value. Each payload word is unpacked least significant byte first.
- R7: The number of delivered bytes is the smaller of the reply's size and `max_len`, with `max_len` sampled when the header is accepted. Bytes beyond that limit are dropped, but their words are still consumed.
- R8: `byte_last` is high only with the final delivered byte of a reply. A reply that delivers zero bytes never raises `byte_valid`.
- R9: `in_ready` is low while bytes of an accepted word are still being delivered. The bytes of one word come out in consecutive cycles.
- R10: A header with any other type pulses `type_err` in the next cycle. Following words without `in_sop` are consumed and dropped until the next header.
- R11: `word_cnt` becomes 1 after a header is accepted. It then rises by one for each payload or discarded word of that reply, and saturates at its all-ones value.
- R12: `resp_done` pulses one cycle after the last word of a recognised reply is accepted. For acknowledge, short and zero-length long replies, that last word is the header itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Reply word present |
| in_sop | input | 1 | Word is the first of a reply |
| in_data | input | 32 | Reply word |
| in_ready | output | 1 | Block can take a word this cycle |
| max_len | input | 16 | Largest byte count the requester accepts |
| byte_valid | output | 1 | Output byte present |
| byte_data | output | 8 | Output byte |
| byte_last | output | 1 | Final delivered byte of the reply |
| ack_valid | output | 1 | Acknowledge reply decoded (one-cycle pulse) |
| ack_err | output | 16 | Last received error bitmap |
| ack_fatal | output | 1 | A serious error bit is set in the bitmap |
| ack_ecc_fixed | output | 1 | Single-bit corrected error reported |
| type_err | output | 1 | Unrecognised reply type (one-cycle pulse) |
| resp_done | output | 1 | Reply fully consumed (one-cycle pulse) |
| word_cnt | output | CNT_W | Words taken for the current reply, saturating |

## Verification
Every flag output is a register loaded on the edge that accepts the word, so `ack_valid`, `ack_err`, `type_err`, `resp_done` and `word_cnt` are due one cycle after acceptance. The first byte of a word is also due in that cycle, and each further byte follows one cycle later. The bench drives a word at a falling edge and holds it until `in_ready` is seen high. It returns on the falling edge right after the accepting rising edge and checks the flags there. Bytes are captured on every falling edge together with their cycle number, so ordering, truncation, the position of `byte_last` and back-to-back delivery are all checked against values the bench works out itself.

// File: rtl/rrp_pkg.sv
// Package: shared constants and types for the read response parser.
// Assumes 32-bit reply words and a 16-bit long-reply byte count.
package rrp_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 16;
    localparam int DT_W   = 6;
    localparam int NW_W   = LEN_W - 1;

    localparam logic [DT_W-1:0] DT_ACK       = 6'h02;
    localparam logic [DT_W-1:0] DT_SHORT1    = 6'h21;
    localparam logic [DT_W-1:0] DT_SHORT2    = 6'h22;
    localparam logic [DT_W-1:0] DT_LONG_GEN  = 6'h1A;
    localparam logic [DT_W-1:0] DT_LONG_DCS  = 6'h1C;

    // Error bits that indicate a failed or unreliable exchange.
    localparam logic [15:0] FATAL_MASK  = 16'hAAF8;
    localparam int          ECC_FIX_BIT = 8;

    typedef enum logic [2:0] {
        K_ACK,
        K_SHORT1,
        K_SHORT2,
        K_LONG,
        K_UNKNOWN
    } rrp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAYLOAD,
        ST_DISCARD
    } rrp_state_e;

endpackage

// File: rtl/rrp_hdr_decode.sv
// Module: rrp_hdr_decode
// Purely combinational header decode. Classifies the data type,
// extracts the long-reply byte count, and computes the delivered
// byte budget and the number of payload words to follow.
// Assumes the input word is a header; the caller qualifies its use.
module rrp_hdr_decode
    import rrp_pkg::*;
(
    input  logic [WORD_W-1:0] hdr,
    input  logic [LEN_W-1:0]  max_len,
    output rrp_kind_e         kind,
    output logic [LEN_W-1:0]  budget,
    output logic [NW_W-1:0]   n_words
);

    logic [LEN_W-1:0] size;
    logic [LEN_W-1:0] wc;
    logic [LEN_W:0]   wc_round;

    // Byte count is split over two header bytes, low byte first.
    assign wc       = {hdr[23:16], hdr[15:8]};
    assign wc_round = {1'b0, wc} + (LEN_W+1)'(3);

    // Classify the data type and pick the reply's natural size.
    always_comb begin
        kind    = K_UNKNOWN;
        size    = '0;
        n_words = '0;
        case (hdr[DT_W-1:0])
            DT_ACK:      kind = K_ACK;
            DT_SHORT1: begin
                kind = K_SHORT1;
                size = LEN_W'(1);
            end
            DT_SHORT2: begin
                kind = K_SHORT2;
                size = LEN_W'(2);
            end
            DT_LONG_GEN, DT_LONG_DCS: begin
                kind    = K_LONG;
                size    = wc;
                n_words = wc_round[LEN_W:2];
            end
            default:     kind = K_UNKNOWN;
        endcase
    end

    // Delivered size is the smaller of natural size and requester limit.
    assign budget = (size < max_len) ? size : max_len;

endmodule

// File: rtl/rrp_unpack.sv
// Module: rrp_unpack
// Byte unpacker with a per-reply byte budget. A loaded word is shifted
// out least significant byte first, one byte per cycle, for at most
// min(bytes per word, remaining budget) bytes. Busy while bytes remain.
// Assumes bud_set and ld are only raised while the unpacker is idle.
module rrp_unpack
    import rrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bud_set,
    input  logic [LEN_W-1:0]  bud_val,
    input  logic              ld,
    input  logic [WORD_W-1:0] ld_word,
    output logic              idle,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_last
);

    localparam int BPW  = WORD_W / BYTE_W;
    localparam int NL_W = $clog2(BPW + 1);

    logic [WORD_W-1:0] sh;
    logic [NL_W-1:0]   nleft;
    logic [LEN_W-1:0]  budget;
    logic [LEN_W-1:0]  base;
    logic [NL_W-1:0]   take;

    // Budget seen by a load in this cycle (new reply or ongoing one).
    assign base = bud_set ? bud_val : budget;
    assign take = (base < LEN_W'(BPW)) ? base[NL_W-1:0] : NL_W'(BPW);

    // Load a word, or shift out one byte and consume one unit of budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            nleft  <= '0;
            budget <= '0;
        end else begin
            if (bud_set) begin
                budget <= bud_val;
            end
            if (ld) begin
                sh    <= ld_word;
                nleft <= take;
            end else if (nleft != '0) begin
                sh     <= sh >> BYTE_W;
                nleft  <= nleft - 1'b1;
                budget <= budget - 1'b1;
            end
        end
    end

    assign idle       = (nleft == '0);
    assign byte_valid = !idle;
    assign byte_data  = sh[BYTE_W-1:0];
    assign byte_last  = byte_valid && (budget == LEN_W'(1));

endmodule

// File: rtl/rrp_ctrl.sv
// Module: rrp_ctrl
// Reply sequencing: takes headers, tracks payload words still owed,
// discards the rest of an unrecognised reply, registers acknowledge
// results and pulses, and keeps the saturating per-reply word count.
// Assumes in_ready comes from the unpacker being idle.
module rrp_ctrl
    import rrp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_ready,
    input  rrp_kind_e         kind,
    input  logic [LEN_W-1:0]  dec_budget,
    input  logic [NW_W-1:0]   dec_words,
    output logic              bud_set,
    output logic [LEN_W-1:0]  bud_val,
    output logic              ld,
    output logic [WORD_W-1:0] ld_word,
    output logic              ack_valid,
    output logic [15:0]       ack_err,
    output logic              ack_fatal,
    output logic              ack_ecc_fixed,
    output logic              type_err,
    output logic              resp_done,
    output logic [CNT_W-1:0]  word_cnt
);

    rrp_state_e      state;
    logic [NW_W-1:0] words_left;
    logic            accept;
    logic            hdr_take;
    logic            pay_take;
    logic            disc_take;
    logic            is_short;
    logic            last_pay;
    logic [15:0]     err_in;

    // Classify the word taken this cycle.
    assign accept    = in_valid && in_ready;
    assign hdr_take  = accept && in_sop && (state != ST_PAYLOAD);
    assign pay_take  = accept && (state == ST_PAYLOAD);
    assign disc_take = accept && !in_sop && (state == ST_DISCARD);
    assign is_short  = (kind == K_SHORT1) || (kind == K_SHORT2);
    assign last_pay  = pay_take && (words_left == NW_W'(1));
    assign err_in    = in_data[23:8];

    // Drive the unpacker: budget on headers, data on short headers and payload.
    always_comb begin
        bud_set = hdr_take;
        bud_val = (is_short || kind == K_LONG) ? dec_budget : '0;
        ld      = (hdr_take && is_short) || pay_take;
        ld_word = pay_take ? in_data : {{BYTE_W{1'b0}}, in_data[WORD_W-1:BYTE_W]};
    end

    // Reply state and the count of payload words still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            words_left <= '0;
        end else if (hdr_take) begin
            words_left <= dec_words;
            case (kind)
                K_LONG:    state <= (dec_words != '0) ? ST_PAYLOAD : ST_IDLE;
                K_UNKNOWN: state <= ST_DISCARD;
                default:   state <= ST_IDLE;
            endcase
        end else if (pay_take) begin
            words_left <= words_left - 1'b1;
            if (last_pay) begin
                state <= ST_IDLE;
            end
        end
    end

    // Saturating count of words taken for the current reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_cnt <= '0;
        end else if (hdr_take) begin
            word_cnt <= CNT_W'(1);
        end else if ((pay_take || disc_take) && (word_cnt != '1)) begin
            word_cnt <= word_cnt + 1'b1;
        end
    end

    // Acknowledge bitmap and its summary flags, held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_err       <= '0;
            ack_fatal     <= 1'b0;
            ack_ecc_fixed <= 1'b0;
        end else if (hdr_take && kind == K_ACK) begin
            ack_err       <= err_in;
            ack_fatal     <= |(err_in & FATAL_MASK);
            ack_ecc_fixed <= err_in[ECC_FIX_BIT];
        end
    end

    // One-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            type_err  <= 1'b0;
            resp_done <= 1'b0;
        end else begin
            ack_valid <= hdr_take && (kind == K_ACK);
            type_err  <= hdr_take && (kind == K_UNKNOWN);
            resp_done <= (hdr_take && (kind == K_ACK || is_short ||
                          (kind == K_LONG && dec_words == '0))) || last_pay;
        end
    end

endmodule

// File: rtl/rd_resp_parser.sv
// Module: rd_resp_parser (top)
// Parses peripheral read replies from a 32-bit word stream into
// acknowledge results and a truncated byte stream.
// Assumes the source marks the first word of each reply with in_sop
// and does not change a held word until it is accepted.
module rd_resp_parser
    import rrp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    input  logic [15:0]       max_len,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              byte_last,
    output logic              ack_valid,
    output logic [15:0]       ack_err,
    output logic              ack_fatal,
    output logic              ack_ecc_fixed,
    output logic              type_err,
    output logic              resp_done,
    output logic [CNT_W-1:0]  word_cnt
);

    rrp_kind_e         kind;
    logic [LEN_W-1:0]  dec_budget;
    logic [NW_W-1:0]   dec_words;
    logic              bud_set;
    logic [LEN_W-1:0]  bud_val;
    logic              ld;
    logic [WORD_W-1:0] ld_word;
    logic              up_idle;

    rrp_hdr_decode u_dec (
        .hdr     (in_data),
        .max_len (max_len),
        .kind    (kind),
        .budget  (dec_budget),
        .n_words (dec_words)
    );

    rrp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_sop        (in_sop),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .kind          (kind),
        .dec_budget    (dec_budget),
        .dec_words     (dec_words),
        .bud_set       (bud_set),
        .bud_val       (bud_val),
        .ld            (ld),
        .ld_word       (ld_word),
        .ack_valid     (ack_valid),
        .ack_err       (ack_err),
        .ack_fatal     (ack_fatal),
        .ack_ecc_fixed (ack_ecc_fixed),
        .type_err      (type_err),
        .resp_done     (resp_done),
        .word_cnt      (word_cnt)
    );

    rrp_unpack u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .bud_set    (bud_set),
        .bud_val    (bud_val),
        .ld         (ld),
        .ld_word    (ld_word),
        .idle       (up_idle),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last)
    );

    assign in_ready = up_idle;

endmodule

// File: rtl/rd_resp_parser_chk.sv
// Module: rd_resp_parser_chk
// Property checker bound to rd_resp_parser; observes ports only.
module rd_resp_parser_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sop,
    input logic [31:0]      in_data,
    input logic             in_ready,
    input logic             byte_valid,
    input logic             byte_last,
    input logic             ack_valid,
    input logic [15:0]      ack_err,
    input logic             type_err,
    input logic [CNT_W-1:0] word_cnt
);

    AST_ACK_FROM_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(in_valid && in_ready && in_sop && in_data[5:0] == 6'h02)); // R3

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |-> $stable(ack_err)); // R3

    AST_LAST_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |-> byte_valid); // R8

    AST_BUSY_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !in_ready); // R9

    AST_TYPE_ERR_FROM_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        type_err |-> $past(in_valid && in_ready && in_sop)); // R10

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt == '1) |=> (word_cnt == '1 || word_cnt == CNT_W'(1))); // R11

endmodule

bind rd_resp_parser rd_resp_parser_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_rd_resp_parser.sv
module sim_rd_resp_parser;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_sop;
    logic [31:0] in_data;
    logic        in_ready;
    logic [15:0] max_len;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_last;
    logic        ack_valid;
    logic [15:0] ack_err;
    logic        ack_fatal;
    logic        ack_ecc_fixed;
    logic        type_err;
    logic        resp_done;
    logic [4:0]  word_cnt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] qd[$];
    bit         ql[$];
    int         qc[$];

    always #10 clk = ~clk;

    rd_resp_parser u0 (.*);

    // Cycle counter for byte timing.
    always @(posedge clk) cyc <= cyc + 1;

    // Capture every delivered byte away from the active edge.
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            qd.push_back(byte_data);
            ql.push_back(byte_last);
            qc.push_back(cyc);
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [31:0] hdr(input logic [5:0] dt, input logic [7:0] b1, input logic [7:0] b2);
        return {8'h00, b2, b1, 2'b00, dt};
    endfunction

    // Drive one word from a falling edge; return at the falling edge after acceptance.
    task automatic put(input logic sop, input logic [31:0] d);
        in_valid = 1'b1;
        in_sop   = sop;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_q();
        qd.delete();
        ql.delete();
        qc.delete();
    endtask

    task automatic t_reset();
        chk("R1", "in_ready", in_ready, 1);
        chk("R1", "byte_valid", byte_valid, 0);
        chk("R1", "ack_valid", ack_valid, 0);
        chk("R1", "ack_err", ack_err, 0);
        chk("R1", "type_err", type_err, 0);
        chk("R1", "resp_done", resp_done, 0);
        chk("R1", "word_cnt", word_cnt, 0);
    endtask

    task automatic t_ack();
        put(1'b1, hdr(6'h02, 8'h00, 8'h01));
        chk("R3", "ack_valid", ack_valid, 1);
        chk("R3", "ack_err", ack_err, 16'h0100);
        chk("R4", "ecc_fixed bit8", ack_ecc_fixed, 1);
        chk("R4", "fatal bit8", ack_fatal, 0);
        chk("R12", "done ack", resp_done, 1);
        chk("R11", "cnt ack", word_cnt, 1);
        idle(1);
        chk("R3", "ack pulse ends", ack_valid, 0);
        chk("R3", "ack_err held", ack_err, 16'h0100);
        put(1'b1, hdr(6'h02, 8'h20, 8'h00));
        chk("R4", "fatal bit5", ack_fatal, 1);
        chk("R4", "ecc_fixed bit5", ack_ecc_fixed, 0);
        put(1'b1, hdr(6'h02, 8'h00, 8'h04));
        chk("R4", "fatal reserved bit10", ack_fatal, 0);
        chk("R3", "ack_err bit10", ack_err, 16'h0400);
    endtask

    task automatic t_stray();
        put(1'b0, hdr(6'h02, 8'hFF, 8'hFF));
        chk("R2", "stray ack_valid", ack_valid, 0);
        chk("R2", "stray ack_err", ack_err, 16'h0400);
        chk("R2", "stray word_cnt", word_cnt, 1);
        chk("R2", "stray done", resp_done, 0);
    endtask

    task automatic t_short();
        max_len = 16'd8;
        clear_q();
        put(1'b1, {8'h00, 8'hBB, 8'hAA, 2'b00, 6'h22});
        chk("R5", "first byte due", byte_valid, 1);
        chk("R12", "done short", resp_done, 1);
        idle(3);
        chk("R5", "two bytes", qd.size(), 2);
        if (qd.size() == 2) begin
            chk("R5", "byte0", qd[0], 8'hAA);
            chk("R5", "byte1", qd[1], 8'hBB);
            chk("R9", "consecutive", qc[1] - qc[0], 1);
            chk("R8", "last pos", {ql[0], ql[1]}, 2'b01);
        end
        clear_q();
        put(1'b1, {16'h0000, 8'hCD, 2'b00, 6'h21});
        idle(2);
        chk("R5", "one byte", qd.size(), 1);
        if (qd.size() == 1) begin
            chk("R5", "short1 data", qd[0], 8'hCD);
            chk("R8", "short1 last", ql[0], 1);
        end
    endtask

    task automatic t_long();
        max_len = 16'd100;
        clear_q();
        put(1'b1, hdr(6'h1C, 8'h06, 8'h00));
        chk("R6", "no byte on header", byte_valid, 0);
        chk("R12", "not done on header", resp_done, 0);
        put(1'b0, 32'h44332211);
        chk("R9", "busy while emitting", in_ready, 0);
        chk("R6", "first payload byte", byte_data, 8'h11);
        put(1'b1, 32'h00006655);
        chk("R12", "done long", resp_done, 1);
        chk("R11", "cnt long", word_cnt, 3);
        idle(5);
        chk("R6", "byte count", qd.size(), 6);
        for (int i = 0; i < 6 && i < qd.size(); i++) begin
            chk("R6", "payload byte", qd[i], 8'h11 * (i + 1));
            chk("R8", "last flag", ql[i], (i == 5) ? 1 : 0);
        end
    endtask

    task automatic t_trunc();
        max_len = 16'd5;
        clear_q();
        put(1'b1, hdr(6'h1C, 8'h04, 8'h01));
        max_len = 16'd100;
        for (int i = 0; i < 65; i++) begin
            put(1'b0, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
            if (i == 64) chk("R12", "done trunc", resp_done, 1);
            else if (i == 63) chk("R12", "not done early", resp_done, 0);
        end
        chk("R11", "cnt saturates", word_cnt, 31);
        idle(5);
        chk("R7", "truncated size", qd.size(), 5);
        for (int i = 0; i < 5 && i < qd.size(); i++) begin
            chk("R7", "kept byte", qd[i], i);
            chk("R8", "trunc last", ql[i], (i == 4) ? 1 : 0);
        end
    endtask

    task automatic t_zero();
        max_len = 16'd0;
        clear_q();
        put(1'b1, hdr(6'h1A, 8'h04, 8'h00));
        put(1'b0, 32'hDEADBEEF);
        chk("R12", "done limit zero", resp_done, 1);
        idle(3);
        chk("R8", "no bytes limit zero", qd.size(), 0);
        max_len = 16'd10;
        put(1'b1, hdr(6'h1A, 8'h00, 8'h00));
        chk("R12", "done empty long", resp_done, 1);
        chk("R11", "cnt empty long", word_cnt, 1);
        idle(2);
        chk("R8", "no bytes empty long", qd.size(), 0);
    endtask

    task automatic t_unknown();
        clear_q();
        put(1'b1, hdr(6'h3F, 8'h11, 8'h22));
        chk("R10", "type_err", type_err, 1);
        chk("R10", "no done", resp_done, 0);
        put(1'b0, hdr(6'h21, 8'h55, 8'h00));
        chk("R10", "type_err pulse", type_err, 0);
        put(1'b0, 32'h12345678);
        chk("R11", "discard count", word_cnt, 3);
        idle(2);
        chk("R10", "no bytes discarded", qd.size(), 0);
        put(1'b1, {16'h0000, 8'h77, 2'b00, 6'h21});
        chk("R2", "recovered header", resp_done, 1);
        idle(2);
        chk("R10", "byte after recover", qd.size(), 1);
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_data  = '0;
        max_len  = 16'd8;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ack();
        t_stray();
        t_short();
        t_long();
        t_trunc();
        t_zero();
        t_unknown();
        idle(2);
        report();
    end

endmodule